// File: doc/BRIEF.md
# TDM Serial Audio Input Deserializer

This block takes time-division-multiplexed audio from a bank of sixteen serial data pins and turns it into parallel sample words. Four lanes are captured side by side. Each lane reads one pin, chosen by a common source base plus a per-lane offset. A bit-rate strobe (`bitTick`) marks each sampling instant. The frame sync (`wsIn`) can be inverted and is read either as a single frame pulse (TDM) or as a two-half left/right clock (I2S). Data capture starts a programmable number of bit ticks after the sync edge.

Bits of each slot are packed into a 32-bit word aligned to the top bit, either first-bit-high or first-bit-low. Per-lane slot masks decide which slots are emitted. Per-lane mute masks substitute a fixed mute word. Accepted words leave one at a time on a valid/ready port, tagged with lane and slot number. A sticky flag records words lost because the port was still busy.

Software configures the block through a small word-addressed register file. The control word holds an enable bit and two active-low sub-resets, one for the capture side and one for the output side. Bring-up order is: hold both resets, release the output side, release the capture side, then set enable.

Top module: `tdm_deser`

## Requirements
- R1: After reset the control word reads 0, the lane map (offset 0x04) reads 0x76543210, status (0x18) reads 0 and `outValid` is 0.
- R2: Registers at offsets 0x04, 0x08–0x14 (slot masks lanes 0–3), 0x1C (mute word) and 0x20–0x2C (mute masks lanes 0–3) read back what was written. Unmapped offsets read 0.
- R3: With control bit 5 clear, the first bit of a slot lands in bit 31. Slot width is control[4:0]+1, and unused low bits are 0. This holds from width 1 up to width 32.
- R4: With control bit 5 set, the first bit of a slot lands in bit 32−W and the last bit in bit 31. Lower bits are 0.
- R5: Control[18:16] gives the skew. The first data bit of a frame is sampled that many bit ticks after the tick on which the sync edge is seen (0 means the same tick).
- R6: With control bit 30 clear (TDM), only a rising sync edge starts a frame. Slots are numbered from 0 upward, and a falling edge does not restart the count.
- R7: With control bit 30 set (I2S), both sync edges restart slot numbering at 0.
- R8: Control bit 25 inverts the sync input before edge detection.
- R9: A slot whose bit in its lane's slot mask is 0 is not emitted.
- R10: An emitted slot whose bit in its lane's mute mask is 1 carries the mute word instead of the captured data.
- R11: Status bit 0 becomes 1 when a slot completes while an earlier word is still undelivered. It stays 1 until a 1 is written to it. Writing 0 leaves it set.
- R12: With enable (bit 31) clear, or capture reset (bit 28) at 0, nothing is captured. Output reset (bit 29) at 0 drops `outValid` on the next cycle.
- R13: Lane L reads pin (control[23:20] + map[4L+3:4L]) mod 16.
- R14: Words of one slot leave lowest lane first. While `outValid` is high and `outReady` is low, data, lane and slot stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Byte offset of register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| bitTick | input | 1 | One-cycle strobe marking a bit sampling instant |
| wsIn | input | 1 | Frame sync input |
| sdIn | input | 16 | Serial data pins |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts word |
| outData | output | 32 | Packed slot word |
| outLane | output | 2 | Lane of the word |
| outSlot | output | 5 | Slot number of the word |

## Verification
On every cycle, the checker confirms three things: a stalled output word stays frozen, the output reset drops `outValid`, and the overflow flag only sets on a lost word and only clears through a write of 1. It also confirms that a disabled block with nothing queued stays silent. Bit packing order, skew alignment, frame restart in each mode, sync inversion, pin selection, masking and muting depend on the serial stimulus. Only the bench's directed frames, with their precomputed words, can show these.

// File: rtl/tdmd_pkg.sv
package tdmd_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int SRC_N   = 16;
  localparam int SRC_W   = $clog2(SRC_N);
  localparam int SLOT_W  = $clog2(WORD_W);
  localparam int LANE_W  = $clog2(LANES);
  localparam int SKEW_W  = 3;
  localparam int ADDR_W  = 6;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int SWAP_FW = 4;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] RIDX_CTRL  = 4'd0;
  localparam logic [IDX_W-1:0] RIDX_MAP   = 4'd1;
  localparam logic [IDX_W-1:0] RIDX_MASK0 = 4'd2;
  localparam logic [IDX_W-1:0] RIDX_STAT  = 4'd6;
  localparam logic [IDX_W-1:0] RIDX_MVAL  = 4'd7;
  localparam logic [IDX_W-1:0] RIDX_MUTE0 = 4'd8;

  // control word bit positions
  localparam int CB_EN   = 31;
  localparam int CB_I2S  = 30;
  localparam int CB_ORST = 29;
  localparam int CB_IRST = 28;
  localparam int CB_INV  = 25;
  localparam int CB_SRC  = 20;
  localparam int CB_SKEW = 16;
  localparam int CB_LSB  = 5;
  localparam int CB_WID  = 0;

  localparam logic [WORD_W-1:0] MAP_RESET = 32'h7654_3210;

  typedef struct packed {
    logic              capture;
    logic              first;
    logic              last;
    logic [SLOT_W-1:0] slot;
  } strobe_t;

  typedef struct packed {
    logic                         outRstN;
    logic                         lsbFirst;
    logic [SLOT_W-1:0]            widthM1;
    logic [SRC_W-1:0]             src;
    logic [WORD_W-1:0]            laneMap;
    logic [WORD_W-1:0]            muteVal;
    logic [LANES-1:0][WORD_W-1:0] slotMask;
    logic [LANES-1:0][WORD_W-1:0] muteMask;
  } cfg_t;
endpackage

// File: rtl/tdmd_ctrl.sv
module tdmd_ctrl
  import tdmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              bitTick,
  input  logic              wsIn,
  input  logic              ovfEvt,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic              enable,
  output logic              ovfFlag
);
  logic [WORD_W-1:0] ctrlReg, mapReg, muteValReg;
  logic [WORD_W-1:0] maskReg [LANES];
  logic [WORD_W-1:0] muteReg [LANES];
  logic [IDX_W-1:0]  regIdx;

  assign regIdx = regAddr[ADDR_W-1:2];

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      mapReg     <= MAP_RESET;
      muteValReg <= '0;
      for (int l = 0; l < LANES; l++) begin
        maskReg[l] <= '0;
        muteReg[l] <= '0;
      end
    end else if (regWrEn) begin
      if (regIdx == RIDX_CTRL) ctrlReg    <= regWrData;
      if (regIdx == RIDX_MAP)  mapReg     <= regWrData;
      if (regIdx == RIDX_MVAL) muteValReg <= regWrData;
      for (int l = 0; l < LANES; l++) begin
        if (regIdx == RIDX_MASK0 + IDX_W'(l)) maskReg[l] <= regWrData;
        if (regIdx == RIDX_MUTE0 + IDX_W'(l)) muteReg[l] <= regWrData;
      end
    end
  end

  // sticky overflow, write one to clear, new event wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else ovfFlag <= ovfEvt |
                    (ovfFlag & ~(regWrEn && regIdx == RIDX_STAT && regWrData[0]));
  end

  always_comb begin
    regRdData = '0;
    case (regIdx)
      RIDX_CTRL: regRdData = ctrlReg;
      RIDX_MAP:  regRdData = mapReg;
      RIDX_STAT: regRdData = {{(WORD_W-1){1'b0}}, ovfFlag};
      RIDX_MVAL: regRdData = muteValReg;
      default:   regRdData = '0;
    endcase
    for (int l = 0; l < LANES; l++) begin
      if (regIdx == RIDX_MASK0 + IDX_W'(l)) regRdData = maskReg[l];
      if (regIdx == RIDX_MUTE0 + IDX_W'(l)) regRdData = muteReg[l];
    end
  end

  always_comb begin
    cfg.outRstN  = ctrlReg[CB_ORST];
    cfg.lsbFirst = ctrlReg[CB_LSB];
    cfg.widthM1  = ctrlReg[CB_WID +: SLOT_W];
    cfg.src      = ctrlReg[CB_SRC +: SRC_W];
    cfg.laneMap  = mapReg;
    cfg.muteVal  = muteValReg;
    for (int l = 0; l < LANES; l++) begin
      cfg.slotMask[l] = maskReg[l];
      cfg.muteMask[l] = muteReg[l];
    end
  end

  // frame / slot sequencer
  logic              inRstN, i2sMode, wsNow, wsPrev, edgeSeen;
  logic              pendStart, running, tickOn, startNow, capture, lastBit;
  logic [SKEW_W-1:0] skew, leadCnt;
  logic [SLOT_W-1:0] bitIdx, slotIdx, curBit, curSlot;

  assign enable   = ctrlReg[CB_EN];
  assign inRstN   = ctrlReg[CB_IRST];
  assign i2sMode  = ctrlReg[CB_I2S];
  assign skew     = ctrlReg[CB_SKEW +: SKEW_W];
  assign wsNow    = wsIn ^ ctrlReg[CB_INV];
  assign edgeSeen = i2sMode ? (wsNow ^ wsPrev) : (wsNow & ~wsPrev);
  assign tickOn   = bitTick & inRstN & enable;
  assign startNow = tickOn & (edgeSeen ? (skew == '0) : (pendStart && leadCnt == '0));
  assign capture  = startNow | (tickOn & running);
  assign curBit   = startNow ? '0 : bitIdx;
  assign curSlot  = startNow ? '0 : slotIdx;
  assign lastBit  = capture && (curBit == cfg.widthM1);

  assign stb.capture = capture;
  assign stb.first   = capture && (curBit == '0);
  assign stb.last    = lastBit;
  assign stb.slot    = curSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsPrev <= 1'b0; pendStart <= 1'b0; leadCnt <= '0;
      running <= 1'b0; bitIdx <= '0; slotIdx <= '0;
    end else if (!inRstN) begin
      wsPrev <= 1'b0; pendStart <= 1'b0; leadCnt <= '0;
      running <= 1'b0; bitIdx <= '0; slotIdx <= '0;
    end else begin
      if (bitTick) wsPrev <= wsNow;
      if (!enable) begin
        running   <= 1'b0;
        pendStart <= 1'b0;
      end else if (bitTick) begin
        if (edgeSeen) begin
          pendStart <= (skew != '0);
          leadCnt   <= skew - SKEW_W'(1);
        end else if (pendStart) begin
          if (leadCnt == '0) pendStart <= 1'b0;
          else leadCnt <= leadCnt - SKEW_W'(1);
        end
        if (capture) begin
          running <= 1'b1;
          if (lastBit) begin
            bitIdx  <= '0;
            slotIdx <= curSlot + SLOT_W'(1);
          end else begin
            bitIdx  <= curBit + SLOT_W'(1);
            slotIdx <= curSlot;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdmd_datapath.sv
module tdmd_datapath
  import tdmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  input  logic [SRC_N-1:0]  sdIn,
  input  logic              outReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic [LANE_W-1:0] outLane,
  output logic [SLOT_W-1:0] outSlot,
  output logic              ovfEvt,
  output logic              pendAny
);
  logic [LANES-1:0][WORD_W-1:0] slotWord;
  logic [LANES-1:0][WORD_W-1:0] holdData;
  logic [LANES-1:0]             accept, muted, pending;
  logic [SLOT_W-1:0]            holdSlot;
  logic [SLOT_W-1:0]            alignShift;
  logic [LANE_W-1:0]            grantIdx;
  logic                         canLoad;

  assign alignShift = SLOT_W'(WORD_W - 1) - cfg.widthM1;

  for (genvar L = 0; L < LANES; L++) begin : gLane
    logic [SRC_W-1:0]  pinSel;
    logic              bitIn;
    logic [WORD_W-1:0] acc, base, nextAcc;

    assign pinSel  = cfg.src + cfg.laneMap[L*SWAP_FW +: SRC_W];
    assign bitIn   = sdIn[pinSel];
    assign base    = stb.first ? '0 : acc;
    assign nextAcc = cfg.lsbFirst ? {bitIn, base[WORD_W-1:1]}
                                  : {base[WORD_W-2:0], bitIn};
    assign slotWord[L] = cfg.lsbFirst ? nextAcc : (nextAcc << alignShift);
    assign accept[L]   = cfg.slotMask[L][stb.slot];
    assign muted[L]    = cfg.muteMask[L][stb.slot];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) acc <= '0;
      else if (stb.capture) acc <= nextAcc;
    end
  end

  assign pendAny = |pending;
  assign canLoad = !outValid || outReady;
  assign ovfEvt  = stb.last && cfg.outRstN && (pendAny || (outValid && !outReady));

  always_comb begin
    grantIdx = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (pending[l]) grantIdx = LANE_W'(l);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      holdData <= '0;
      holdSlot <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outLane  <= '0;
      outSlot  <= '0;
    end else if (!cfg.outRstN) begin
      pending  <= '0;
      outValid <= 1'b0;
    end else begin
      if (canLoad) begin
        if (pendAny) begin
          outValid <= 1'b1;
          outData  <= holdData[grantIdx];
          outLane  <= grantIdx;
          outSlot  <= holdSlot;
        end else begin
          outValid <= 1'b0;
        end
      end
      if (stb.last) begin
        pending  <= accept;
        holdSlot <= stb.slot;
        for (int l = 0; l < LANES; l++)
          holdData[l] <= muted[l] ? cfg.muteVal : slotWord[l];
      end else if (canLoad && pendAny) begin
        pending[grantIdx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_deser.sv
module tdm_deser
  import tdmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              bitTick,
  input  logic              wsIn,
  input  logic [SRC_N-1:0]  sdIn,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic [LANE_W-1:0] outLane,
  output logic [SLOT_W-1:0] outSlot
);
  cfg_t    cfgBus;
  strobe_t stbBus;
  logic    ovfEvt, ovfFlag, enable, pendAny;

  tdmd_ctrl ctrlInst (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .bitTick(bitTick), .wsIn(wsIn), .ovfEvt(ovfEvt),
    .cfg(cfgBus), .stb(stbBus), .enable(enable), .ovfFlag(ovfFlag)
  );

  tdmd_datapath dpInst (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .stb(stbBus), .sdIn(sdIn),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outLane(outLane), .outSlot(outSlot), .ovfEvt(ovfEvt), .pendAny(pendAny)
  );
endmodule

// File: rtl/tdm_deser_chk.sv
module tdm_deser_chk
  import tdmd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WORD_W-1:0] regWrData,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic [LANE_W-1:0] outLane,
  input logic [SLOT_W-1:0] outSlot,
  input logic              outRstN,
  input logic              enable,
  input logic              pendAny,
  input logic              ovfEvt,
  input logic              ovfFlag
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !regWrEn |=>
      outValid && $stable(outData) && $stable(outLane) && $stable(outSlot)); // R14

  AST_OUT_RESET_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !outRstN |=> !outValid); // R12

  AST_IDLE_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !outValid && !pendAny && !regWrEn |=> !outValid); // R12

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(regWrEn && regAddr[ADDR_W-1:2] == RIDX_STAT && regWrData[0]) |=> ovfFlag); // R11

  AST_OVF_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !ovfFlag && !ovfEvt |=> !ovfFlag); // R11
endmodule

bind tdm_deser tdm_deser_chk chkInst (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outLane(outLane),
  .outSlot(outSlot), .outRstN(cfgBus.outRstN), .enable(enable), .pendAny(pendAny),
  .ovfEvt(ovfEvt), .ovfFlag(ovfFlag)
);

// File: tb/tdm_deser_test.sv
module tdm_deser_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [5:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        bitTick, wsIn, outValid, outReady;
  logic [15:0] sdIn;
  logic [31:0] outData;
  logic [1:0]  outLane;
  logic [4:0]  outSlot;

  always #10 clk = ~clk;

  tdm_deser uut (.*);

  typedef struct { logic [31:0] d; logic [1:0] l; logic [4:0] s; } rec_t;
  rec_t got[$];
  rec_t exq[$];

  int total = 0;
  int bad = 0;
  logic [31:0] bMask [4];
  logic [31:0] bMute [4];
  logic [31:0] bMuteVal;
  logic [31:0] bMap;
  logic        bLsb;

  always @(negedge clk)
    if (outValid === 1'b1 && outReady === 1'b1) got.push_back('{outData, outLane, outSlot});

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1 regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1 regAddr = a; #2 d = regRdData;
  endtask

  function automatic logic [31:0] mkCtrl(input logic en, i2s, oR, iR, inv,
      input logic [3:0] src, input logic [2:0] skew, input logic lsb, input logic [4:0] wm1);
    logic [31:0] c = '0;
    c[31] = en; c[30] = i2s; c[29] = oR; c[28] = iR; c[25] = inv;
    c[23:20] = src; c[18:16] = skew; c[5] = lsb; c[4:0] = wm1;
    return c;
  endfunction

  task automatic setup(input logic en, iR, i2s, inv, input logic [3:0] src,
      input logic [2:0] skew, input logic lsb, input int width);
    wr(6'h00, mkCtrl(1'b0, i2s, 1'b1, iR, inv, src, skew, lsb, 5'(width - 1)));
    wr(6'h00, mkCtrl(en, i2s, 1'b1, iR, inv, src, skew, lsb, 5'(width - 1)));
    bLsb = lsb;
  endtask

  task automatic setMasks(input logic [31:0] m0, m1, m2, m3, u0, u1, u2, u3, mv);
    bMask[0] = m0; bMask[1] = m1; bMask[2] = m2; bMask[3] = m3;
    bMute[0] = u0; bMute[1] = u1; bMute[2] = u2; bMute[3] = u3;
    bMuteVal = mv;
    for (int l = 0; l < 4; l++) begin
      wr(6'(8 + 4 * l), bMask[l]);
      wr(6'(32 + 4 * l), bMute[l]);
    end
    wr(6'h1C, mv);
  endtask

  function automatic logic [31:0] patt(input int l, input int s, input int w);
    logic [31:0] v = 32'h9E37_79B9 * 32'(l * 8 + s + 3);
    v = v ^ 32'h5A5A_1234;
    if (w < 32) v = v & ((32'h1 << w) - 32'h1);
    return v;
  endfunction

  function automatic logic [31:0] packed_word(input logic [31:0] v, input int w, input logic lsb);
    logic [31:0] r = '0;
    if (!lsb) return v << (32 - w);
    for (int k = 0; k < w; k++) r[32 - w + k] = v[w - 1 - k];
    return r;
  endfunction

  task automatic step(input logic ws, input logic [15:0] sd);
    @(posedge clk); #1 wsIn = ws; sdIn = sd; bitTick = 1'b1;
    @(posedge clk); #1 bitTick = 1'b0;
    @(posedge clk); @(posedge clk);
  endtask

  task automatic streamFrame(input int width, input int slots, input int skew,
      input logic i2s, input logic inv, input int wsLen, input logic [3:0] src);
    int lanePin [4];
    int nTot = width * slots;
    int half = nTot / 2;
    for (int l = 0; l < 4; l++) lanePin[l] = int'(4'(src + bMap[4*l +: 4]));
    step((i2s ? 1'b1 : 1'b0) ^ inv, 16'hFFFF);
    for (int t = 0; t < nTot + skew; t++) begin
      int p = t - skew;
      logic lvl = i2s ? (t >= half) : (t < wsLen);
      logic [15:0] sd = 16'hFFFF;
      if (p >= 0) begin
        sd = '0;
        for (int l = 0; l < 4; l++) begin
          logic [31:0] v = patt(l, p / width, width);
          sd[lanePin[l]] = v[width - 1 - (p % width)];
        end
      end
      step(lvl ^ inv, sd);
    end
    for (int s = 0; s < slots; s++) begin
      int sn = i2s ? (s % (slots / 2)) : s;
      for (int l = 0; l < 4; l++)
        if (bMask[l][sn])
          exq.push_back('{bMute[l][sn] ? bMuteVal : packed_word(patt(l, s, width), width, bLsb),
                          2'(l), 5'(sn)});
    end
    repeat (24) @(posedge clk);
  endtask

  task automatic compareQ(input string req);
    int n = (got.size() < exq.size()) ? got.size() : exq.size();
    check(req, "word count", 32'(got.size()), 32'(exq.size()));
    for (int i = 0; i < n; i++) begin
      check(req, "data", got[i].d, exq[i].d);
      check(req, "lane", 32'(got[i].l), 32'(exq[i].l));
      check(req, "slot", 32'(got[i].s), 32'(exq[i].s));
    end
    got.delete();
    exq.delete();
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(6'h00, v); check("R1", "ctrl", v, 32'h0);
    rd(6'h04, v); check("R1", "lane map", v, 32'h7654_3210);
    rd(6'h18, v); check("R1", "status", v, 32'h0);
    check("R1", "outValid", 32'(outValid), 32'h0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    wr(6'h10, 32'hDEAD_BEEF); rd(6'h10, v); check("R2", "mask lane2", v, 32'hDEAD_BEEF);
    wr(6'h1C, 32'h1234_5678); rd(6'h1C, v); check("R2", "mute word", v, 32'h1234_5678);
    wr(6'h2C, 32'hA5A5_0F0F); rd(6'h2C, v); check("R2", "mute lane3", v, 32'hA5A5_0F0F);
    wr(6'h04, 32'h0123_4567); rd(6'h04, v); check("R2", "lane map", v, 32'h0123_4567);
    rd(6'h30, v); check("R2", "unmapped", v, 32'h0);
    wr(6'h04, 32'h7654_3210); bMap = 32'h7654_3210;
  endtask

  task automatic testTdm();   // R3 R6: falling sync edge mid slot must not restart
    setMasks('1, '1, '1, '1, 0, 0, 0, 0, 0);
    setup(1, 1, 0, 0, 4'd0, 3'd0, 0, 8);
    streamFrame(8, 4, 0, 0, 0, 7, 4'd0);
    compareQ("R3/R6 tdm msb-first");
  endtask

  task automatic testSkew();  // R5
    setup(1, 1, 0, 0, 4'd0, 3'd3, 0, 16);
    streamFrame(16, 2, 3, 0, 0, 1, 4'd0);
    compareQ("R5 skew3");
  endtask

  task automatic testLsb();   // R4
    setup(1, 1, 0, 0, 4'd0, 3'd1, 1, 12);
    streamFrame(12, 3, 1, 0, 0, 1, 4'd0);
    compareQ("R4 lsb-first");
  endtask

  task automatic testI2s();   // R7
    setup(1, 1, 1, 0, 4'd0, 3'd1, 0, 16);
    streamFrame(16, 4, 1, 1, 0, 0, 4'd0);
    compareQ("R7 i2s halves");
  endtask

  task automatic testInvert(); // R8
    setup(1, 1, 0, 1, 4'd0, 3'd2, 0, 8);
    streamFrame(8, 2, 2, 0, 1, 1, 4'd0);
    compareQ("R8 inverted sync");
  endtask

  task automatic testWide();  // R3 boundary width 32
    setup(1, 1, 0, 0, 4'd0, 3'd0, 0, 32);
    streamFrame(32, 2, 0, 0, 0, 1, 4'd0);
    compareQ("R3 width32");
  endtask

  task automatic testMaskMute(); // R9 R10
    setMasks(32'h5, 32'hF, 32'h0, 32'h2, 0, 32'h2, 0, 32'h2, 32'hCAFE_F00D);
    setup(1, 1, 0, 0, 4'd0, 3'd0, 0, 8);
    streamFrame(8, 4, 0, 0, 0, 1, 4'd0);
    compareQ("R9/R10 mask and mute");
    setMasks('1, '1, '1, '1, 0, 0, 0, 0, 0);
  endtask

  task automatic testSource(); // R13
    wr(6'h04, 32'h7654_0123); bMap = 32'h7654_0123;
    setup(1, 1, 0, 0, 4'd14, 3'd1, 0, 8);
    streamFrame(8, 2, 1, 0, 0, 1, 4'd14);
    compareQ("R13 pin select");
    wr(6'h04, 32'h7654_3210); bMap = 32'h7654_3210;
  endtask

  task automatic testOverflow(); // R11 R14
    logic [31:0] v, held;
    setMasks('1, '1, 0, 0, 0, 0, 0, 0, 0);
    setup(1, 1, 0, 0, 4'd0, 3'd0, 0, 8);
    outReady = 1'b0;
    streamFrame(8, 2, 0, 0, 0, 1, 4'd0);
    exq.delete();
    @(negedge clk); held = outData;
    check("R14", "valid while stalled", 32'(outValid), 32'h1);
    check("R14", "lowest lane first", 32'(outLane), 32'h0);
    repeat (5) @(negedge clk);
    check("R14", "stalled data stable", outData, held);
    rd(6'h18, v); check("R11", "overflow set", v, 32'h1);
    wr(6'h18, 32'h0); rd(6'h18, v); check("R11", "write 0 keeps", v, 32'h1);
    @(posedge clk); #1 outReady = 1'b1;
    repeat (12) @(posedge clk);
    exq.push_back('{packed_word(patt(0, 0, 8), 8, 0), 2'd0, 5'd0});
    exq.push_back('{packed_word(patt(0, 1, 8), 8, 0), 2'd0, 5'd1});
    exq.push_back('{packed_word(patt(1, 1, 8), 8, 0), 2'd1, 5'd1});
    compareQ("R11/R14 overflow replay");
    wr(6'h18, 32'h1); rd(6'h18, v); check("R11", "write 1 clears", v, 32'h0);
    setMasks('1, '1, '1, '1, 0, 0, 0, 0, 0);
  endtask

  task automatic testGates(); // R12
    setup(0, 1, 0, 0, 4'd0, 3'd0, 0, 8);
    streamFrame(8, 2, 0, 0, 0, 1, 4'd0);
    exq.delete();
    check("R12", "disabled words", 32'(got.size()), 32'h0);
    got.delete();
    setup(1, 0, 0, 0, 4'd0, 3'd0, 0, 8);
    streamFrame(8, 2, 0, 0, 0, 1, 4'd0);
    exq.delete();
    check("R12", "capture reset words", 32'(got.size()), 32'h0);
    got.delete();
    setup(1, 1, 0, 0, 4'd0, 3'd0, 0, 8);
    outReady = 1'b0;
    streamFrame(8, 1, 0, 0, 0, 1, 4'd0);
    exq.delete();
    check("R12", "valid before out reset", 32'(outValid), 32'h1);
    wr(6'h00, mkCtrl(1, 0, 0, 1, 0, 4'd0, 3'd0, 0, 5'd7));
    @(posedge clk); #1;
    check("R12", "valid after out reset", 32'(outValid), 32'h0);
    outReady = 1'b1;
    got.delete();
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    bitTick = 1'b0; wsIn = 1'b0; sdIn = '0; outReady = 1'b1;
    bMap = 32'h7654_3210; bLsb = 1'b0; bMuteVal = '0;
    for (int l = 0; l < 4; l++) begin bMask[l] = '0; bMute[l] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRegs();
    testTdm();
    testSkew();
    testLsb();
    testI2s();
    testInvert();
    testWide();
    testMaskMute();
    testSource();
    testOverflow();
    testGates();
    summary();
  end
endmodule